// File: doc/BRIEF.md
# Dual-Buffer Transmit Queue Selector

This block sits between the transmit queues and the eight output ports of a packet pipeline. The eight ports alternate between network-facing (even index: 0, 2, 4, 6) and host-facing (odd index: 1, 3, 5, 7) destinations. Eight standard queues feed them one to one. Four extra replay queues hold pre-loaded packet traces, and replay queue k belongs to network port 2k. Every stream uses a valid/ready handshake and carries an end-of-packet flag. Each replay stream also carries an end-of-trace flag on the final beat of its trace.

While the global generator enable is set, a per-port select bit decides whether network port 2k drains its standard queue or its replay queue. The unselected buffer can therefore be refilled while the other transmits. The block changes a port's source only between packets. It counts the complete passes through each trace. At the end of every pass it sends a rewind pulse to the replay queue, which restarts that queue's read pointer. After the programmed number of passes it raises a per-port done flag and stops that replay. An iteration count of zero means the trace repeats without limit. When the enable is clear, the block acts as a plain eight-queue pass-through.

Top module: `txq_port_select`

## Requirements
- R1: With gen_en low and no replay packet in flight on a port, every port i passes standard queue i through unchanged. The output valid, data lane `[i*DATA_W +: DATA_W]` and end-of-packet flag follow the queue, std_ready[i] follows out_ready[i], and rep_ready stays low.
- R2: Host-facing ports (odd indices 1, 3, 5, 7) always pass their standard queue through, whatever the values of gen_en and rep_sel.
- R3: At a packet boundary, with gen_en high and rep_sel[k] = 1, network port 2k is fed from replay queue k. With rep_sel[k] = 0, it is fed from standard queue 2k.
- R4: Once a packet has started on a network port, every remaining beat up to and including its end-of-packet beat comes from the same source. This holds even if gen_en or rep_sel changes during the packet.
- R5: The source not selected for a network port sees its ready signal held low, so no beat of it is consumed.
- R6: Each accepted replay beat with rep_eot set produces a one-cycle pulse on rep_rewind[k] in the following cycle.
- R7: With iter_limit[k] = N > 0, rep_done[k] rises in the cycle after the N-th end-of-trace beat is accepted. From then on rep_ready[k] is low and the port emits no replay beats.
- R8: With iter_limit[k] = 0, rep_done[k] never rises, however many passes are completed.
- R9: Clearing gen_en resets each port's pass count and clears rep_done in the next cycle, so a later enable replays the full programmed count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Global generator enable |
| rep_sel | input | N_MAC | Per network port: 1 selects the replay queue |
| iter_limit | input | N_MAC*ITER_W | Passes per trace, lane k for replay queue k, 0 = unlimited |
| std_valid | input | 2*N_MAC | Standard queue beat valid |
| std_data | input | 2*N_MAC*DATA_W | Standard queue beat data, lane i for queue i |
| std_eop | input | 2*N_MAC | Standard queue end of packet |
| std_ready | output | 2*N_MAC | Standard queue beat accepted when high with valid |
| rep_valid | input | N_MAC | Replay queue beat valid |
| rep_data | input | N_MAC*DATA_W | Replay queue beat data |
| rep_eop | input | N_MAC | Replay queue end of packet |
| rep_eot | input | N_MAC | Replay queue end of trace (last beat of the trace) |
| rep_ready | output | N_MAC | Replay queue beat accepted when high with valid |
| rep_rewind | output | N_MAC | One-cycle pulse: restart the trace read pointer |
| rep_done | output | N_MAC | Programmed passes complete; replay halted |
| out_valid | output | 2*N_MAC | Output port beat valid |
| out_data | output | 2*N_MAC*DATA_W | Output port beat data |
| out_eop | output | 2*N_MAC | Output port end of packet |
| out_ready | input | 2*N_MAC | Downstream ready per output port |

## Verification
The hardest case to reach from the ports is a source request that changes while a packet is only partly transferred. In that case the port must keep draining the old source and switch only after the end-of-packet beat. The stimulus builds this up one beat at a time. It holds end-of-packet low so that a first beat is accepted, then flips the select bit or drops the enable between edges. It checks that the original queue still owns the port before it releases the end-of-packet beat. Iteration limits are driven by single end-of-trace beats spaced a cycle apart, so the rewind pulse and the done flag can be tied to exact passes.

// File: rtl/txsel_pkg.sv
// Package: shared types and helpers for the transmit queue selector.
// Assumes network ports sit at even output indices, host ports at odd ones.
package txsel_pkg;

    // Source currently feeding a network port.
    typedef enum logic {
        SRC_STD = 1'b0,
        SRC_REP = 1'b1
    } src_e;

    // Output port index served by replay queue k.
    function automatic int net_port(input int k);
        return 2 * k;
    endfunction

endpackage

// File: rtl/txsel_port_mux.sv
// Module: two-source multiplexer for one network output port.
// Picks the standard or replay stream and locks the choice for the
// duration of a packet. Assumes rep_valid is already gated by the caller
// when replay has finished; ready is combinational from out_ready.
module txsel_port_mux
    import txsel_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want_rep,
    input  logic              std_valid,
    input  logic [DATA_W-1:0] std_data,
    input  logic              std_eop,
    output logic              std_ready,
    input  logic              rep_valid,
    input  logic [DATA_W-1:0] rep_data,
    input  logic              rep_eop,
    output logic              rep_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eop,
    input  logic              out_ready
);

    src_e locked_src;
    logic mid_pkt;
    src_e live_src;
    logic beat_taken;

    // Source in force: locked mid-packet, otherwise follow the request.
    always_comb begin
        if (mid_pkt) live_src = locked_src;
        else         live_src = want_rep ? SRC_REP : SRC_STD;
    end

    // Route the chosen stream to the output and ready back to it.
    always_comb begin
        if (live_src == SRC_REP) begin
            out_valid = rep_valid;
            out_data  = rep_data;
            out_eop   = rep_eop;
        end else begin
            out_valid = std_valid;
            out_data  = std_data;
            out_eop   = std_eop;
        end
        std_ready = out_ready && (live_src == SRC_STD);
        rep_ready = out_ready && (live_src == SRC_REP);
    end

    assign beat_taken = out_valid && out_ready;

    // Track packet boundaries and hold the source while inside a packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_pkt    <= 1'b0;
            locked_src <= SRC_STD;
        end else if (beat_taken) begin
            mid_pkt    <= !out_eop;
            locked_src <= live_src;
        end
    end

endmodule

// File: rtl/txsel_replay_iter.sv
// Module: pass counter for one replay queue.
// Counts accepted end-of-trace beats, pulses rewind after each, and sets
// done when the programmed count is reached (0 = endless). A clear input
// restarts the count; it assumes the limit is stable while replaying.
module txsel_replay_iter #(
    parameter int ITER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              eot_taken,
    input  logic [ITER_W-1:0] limit,
    output logic              rewind,
    output logic              done
);

    localparam int CNT_W = ITER_W + 1;

    logic [CNT_W-1:0] passes;
    logic [CNT_W-1:0] passes_next;
    logic             final_pass;

    assign passes_next = passes + CNT_W'(1);
    assign final_pass  = (limit != '0) && (passes_next >= CNT_W'(limit));

    // Pass count and done flag; clear has priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            passes <= '0;
            done   <= 1'b0;
        end else if (eot_taken && !done) begin
            if (final_pass) done <= 1'b1;
            if (limit != '0) passes <= passes_next;
        end
    end

    // One-cycle rewind request after each completed pass.
    always_ff @(posedge clk) begin
        if (!rst_n) rewind <= 1'b0;
        else        rewind <= eot_taken;
    end

endmodule

// File: rtl/txq_port_select.sv
// Module: top of the transmit queue selector.
// Maps eight standard queues and four replay queues onto eight output
// ports. Even ports may switch to replay under gen_en and rep_sel; odd
// ports are fixed pass-through. Assumes queue memory lives elsewhere and
// honours rep_rewind by restarting its trace.
module txq_port_select
    import txsel_pkg::*;
#(
    parameter int N_MAC  = 4,
    parameter int DATA_W = 64,
    parameter int ITER_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        gen_en,
    input  logic [N_MAC-1:0]            rep_sel,
    input  logic [N_MAC*ITER_W-1:0]     iter_limit,
    input  logic [2*N_MAC-1:0]          std_valid,
    input  logic [2*N_MAC*DATA_W-1:0]   std_data,
    input  logic [2*N_MAC-1:0]          std_eop,
    output logic [2*N_MAC-1:0]          std_ready,
    input  logic [N_MAC-1:0]            rep_valid,
    input  logic [N_MAC*DATA_W-1:0]     rep_data,
    input  logic [N_MAC-1:0]            rep_eop,
    input  logic [N_MAC-1:0]            rep_eot,
    output logic [N_MAC-1:0]            rep_ready,
    output logic [N_MAC-1:0]            rep_rewind,
    output logic [N_MAC-1:0]            rep_done,
    output logic [2*N_MAC-1:0]          out_valid,
    output logic [2*N_MAC*DATA_W-1:0]   out_data,
    output logic [2*N_MAC-1:0]          out_eop,
    input  logic [2*N_MAC-1:0]          out_ready
);

    localparam int N_PORT = 2 * N_MAC;

    for (genvar k = 0; k < N_MAC; k++) begin : g_net
        localparam int NP = net_port(k);
        localparam int HP = NP + 1;

        logic rep_valid_g;
        logic mux_rep_ready;
        logic eot_taken;

        // Halted replay offers nothing to the port.
        assign rep_valid_g  = rep_valid[k] && !rep_done[k];
        assign rep_ready[k] = mux_rep_ready && !rep_done[k];
        assign eot_taken    = rep_valid_g && rep_ready[k] && rep_eot[k];

        txsel_port_mux #(.DATA_W(DATA_W)) u_mux (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_rep  (gen_en && rep_sel[k]),
            .std_valid (std_valid[NP]),
            .std_data  (std_data[NP*DATA_W +: DATA_W]),
            .std_eop   (std_eop[NP]),
            .std_ready (std_ready[NP]),
            .rep_valid (rep_valid_g),
            .rep_data  (rep_data[k*DATA_W +: DATA_W]),
            .rep_eop   (rep_eop[k]),
            .rep_ready (mux_rep_ready),
            .out_valid (out_valid[NP]),
            .out_data  (out_data[NP*DATA_W +: DATA_W]),
            .out_eop   (out_eop[NP]),
            .out_ready (out_ready[NP])
        );

        txsel_replay_iter #(.ITER_W(ITER_W)) u_iter (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (!gen_en),
            .eot_taken (eot_taken),
            .limit     (iter_limit[k*ITER_W +: ITER_W]),
            .rewind    (rep_rewind[k]),
            .done      (rep_done[k])
        );

        // Host-facing partner port: fixed straight connection.
        assign out_valid[HP]                 = std_valid[HP];
        assign out_data[HP*DATA_W +: DATA_W] = std_data[HP*DATA_W +: DATA_W];
        assign out_eop[HP]                   = std_eop[HP];
        assign std_ready[HP]                 = out_ready[HP];
    end

    if (N_PORT != 2 * N_MAC) begin : g_bad_cfg
        initial $error("port count mismatch");
    end

endmodule

// File: rtl/txsel_chk.sv
// Module: assertion checker for txq_port_select, bound to every instance.
// Tracks packet ownership per network port from the port handshakes alone.
module txsel_chk #(
    parameter int N_MAC  = 4,
    parameter int DATA_W = 64,
    parameter int ITER_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      gen_en,
    input logic [N_MAC-1:0]          rep_sel,
    input logic [2*N_MAC-1:0]        std_valid,
    input logic [2*N_MAC*DATA_W-1:0] std_data,
    input logic [2*N_MAC-1:0]        std_eop,
    input logic [2*N_MAC-1:0]        std_ready,
    input logic [N_MAC-1:0]          rep_valid,
    input logic [N_MAC-1:0]          rep_eop,
    input logic [N_MAC-1:0]          rep_eot,
    input logic [N_MAC-1:0]          rep_ready,
    input logic [N_MAC-1:0]          rep_rewind,
    input logic [N_MAC-1:0]          rep_done,
    input logic [2*N_MAC-1:0]        out_valid,
    input logic [2*N_MAC*DATA_W-1:0] out_data,
    input logic [2*N_MAC-1:0]        out_ready
);

    for (genvar k = 0; k < N_MAC; k++) begin : g_k
        localparam int NP = 2 * k;
        localparam int HP = 2 * k + 1;

        logic in_rep_pkt;
        logic in_std_pkt;

        // Observed packet ownership from accepted beats.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_rep_pkt <= 1'b0;
                in_std_pkt <= 1'b0;
            end else begin
                if (rep_valid[k] && rep_ready[k]) in_rep_pkt <= !rep_eop[k];
                if (std_valid[NP] && std_ready[NP]) in_std_pkt <= !std_eop[NP];
            end
        end

        p_host_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[HP] == std_valid[HP]) && (std_ready[HP] == out_ready[HP])
            && (out_data[HP*DATA_W +: DATA_W] == std_data[HP*DATA_W +: DATA_W]));

        p_rep_owns_r4: assert property (@(posedge clk) disable iff (!rst_n)
            in_rep_pkt |-> !std_ready[NP]);

        p_std_owns_r4: assert property (@(posedge clk) disable iff (!rst_n)
            in_std_pkt |-> !rep_ready[k]);

        p_one_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(std_ready[NP] && rep_ready[k]));

        p_idle_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!gen_en && !in_rep_pkt) |-> !rep_ready[k]);

        p_rewind_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rep_valid[k] && rep_ready[k] && rep_eot[k]) |=> rep_rewind[k]);

        p_done_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rep_done[k] |-> !rep_ready[k]);

        p_clear_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_en |=> !rep_done[k]);

        p_select_std_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!rep_sel[k] && !in_rep_pkt) |-> !rep_ready[k]);
    end

endmodule

bind txq_port_select txsel_chk #(
    .N_MAC  (N_MAC),
    .DATA_W (DATA_W),
    .ITER_W (ITER_W)
) u_txsel_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (gen_en),
    .rep_sel    (rep_sel),
    .std_valid  (std_valid),
    .std_data   (std_data),
    .std_eop    (std_eop),
    .std_ready  (std_ready),
    .rep_valid  (rep_valid),
    .rep_eop    (rep_eop),
    .rep_eot    (rep_eot),
    .rep_ready  (rep_ready),
    .rep_rewind (rep_rewind),
    .rep_done   (rep_done),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready)
);

// File: tb/tb_txq_port_select.sv
module tb_txq_port_select;

    localparam int CLK_PERIOD = 10;
    localparam int N_MAC  = 4;
    localparam int DW     = 16;
    localparam int IW     = 8;
    localparam int NP     = 2 * N_MAC;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 gen_en;
    logic [N_MAC-1:0]     rep_sel;
    logic [N_MAC*IW-1:0]  iter_limit;
    logic [NP-1:0]        std_valid;
    logic [NP*DW-1:0]     std_data;
    logic [NP-1:0]        std_eop;
    logic [NP-1:0]        std_ready;
    logic [N_MAC-1:0]     rep_valid;
    logic [N_MAC*DW-1:0]  rep_data;
    logic [N_MAC-1:0]     rep_eop;
    logic [N_MAC-1:0]     rep_eot;
    logic [N_MAC-1:0]     rep_ready;
    logic [N_MAC-1:0]     rep_rewind;
    logic [N_MAC-1:0]     rep_done;
    logic [NP-1:0]        out_valid;
    logic [NP*DW-1:0]     out_data;
    logic [NP-1:0]        out_eop;
    logic [NP-1:0]        out_ready;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    txq_port_select #(.N_MAC(N_MAC), .DATA_W(DW), .ITER_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .rep_sel(rep_sel),
        .iter_limit(iter_limit), .std_valid(std_valid), .std_data(std_data),
        .std_eop(std_eop), .std_ready(std_ready), .rep_valid(rep_valid),
        .rep_data(rep_data), .rep_eop(rep_eop), .rep_eot(rep_eot),
        .rep_ready(rep_ready), .rep_rewind(rep_rewind), .rep_done(rep_done),
        .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop),
        .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane(input logic [NP*DW-1:0] v, input int i);
        return v[i*DW +: DW];
    endfunction

    // Scenario: reset state.
    task automatic t_reset();
        rst_n = 1'b0; gen_en = 1'b0; rep_sel = '0; iter_limit = '0;
        std_valid = '0; std_eop = '1; rep_valid = '0; rep_eop = '1; rep_eot = '0;
        out_ready = '1;
        for (int i = 0; i < NP; i++) std_data[i*DW +: DW] = DW'(16'hA000 + i);
        for (int k = 0; k < N_MAC; k++) rep_data[k*DW +: DW] = DW'(16'hB000 + k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset done", 64'(rep_done), 64'h0);
        chk("R6 reset rewind", 64'(rep_rewind), 64'h0);
        chk("R1 reset out_valid", 64'(out_valid), 64'h0);
    endtask

    // Scenario R1: disabled, all standard queues straight through.
    task automatic t_disabled();
        gen_en = 1'b0; rep_sel = '1; std_valid = '1; rep_valid = '1;
        @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'hFF);
        chk("R1 out_data", 64'(out_data), 64'(std_data));
        chk("R1 std_ready", 64'(std_ready), 64'hFF);
        chk("R5 rep_ready disabled", 64'(rep_ready), 64'h0);
        out_ready = 8'h0F;
        @(negedge clk);
        chk("R1 std_ready follows out_ready", 64'(std_ready), 64'h0F);
        out_ready = '1;
    endtask

    // Scenario R2/R3/R5: mixed selection with generator on.
    task automatic t_select();
        gen_en = 1'b1; rep_sel = 4'b0101;
        @(negedge clk);
        chk("R3 port0 from replay0", 64'(lane(out_data, 0)), 64'hB000);
        chk("R3 port2 from std2", 64'(lane(out_data, 2)), 64'hA002);
        chk("R3 port4 from replay2", 64'(lane(out_data, 4)), 64'hB002);
        chk("R3 port6 from std6", 64'(lane(out_data, 6)), 64'hA006);
        chk("R5 std_ready", 64'(std_ready), 64'hEE);
        chk("R5 rep_ready", 64'(rep_ready), 64'h5);
        for (int i = 1; i < NP; i += 2)
            chk("R2 host port data", 64'(lane(out_data, i)), 64'(16'hA000 + i));
        rep_sel = 4'b1111;
        @(negedge clk);
        chk("R2 host readies with all replay", 64'(std_ready), 64'hAA);
    endtask

    // Scenario R4: source held until end of packet, both directions.
    task automatic t_boundary();
        gen_en = 1'b1; rep_sel = 4'b0000; std_eop[0] = 1'b0;
        @(negedge clk);           // one non-final std beat taken at next edge
        @(negedge clk);
        rep_sel[0] = 1'b1;
        @(negedge clk);
        chk("R4 std keeps port mid packet", 64'(lane(out_data, 0)), 64'hA000);
        chk("R4 replay held off mid packet", 64'(rep_ready[0]), 64'h0);
        std_eop[0] = 1'b1;
        @(negedge clk);           // final std beat taken
        chk("R3 switch after eop", 64'(lane(out_data, 0)), 64'hB000);
        chk("R3 replay ready after eop", 64'(rep_ready[0]), 64'h1);
        rep_eop[0] = 1'b0;
        @(negedge clk);           // non-final replay beat taken
        gen_en = 1'b0;
        @(negedge clk);
        chk("R4 replay keeps port after disable", 64'(rep_ready[0]), 64'h1);
        chk("R4 std held off mid replay packet", 64'(std_ready[0]), 64'h0);
        rep_eop[0] = 1'b1;
        @(negedge clk);           // final replay beat taken
        chk("R1 back to std after eop", 64'(lane(out_data, 0)), 64'hA000);
        chk("R1 replay idle after eop", 64'(rep_ready[0]), 64'h0);
    endtask

    // One end-of-trace beat on replay queue 0.
    task automatic eot_beat();
        rep_valid[0] = 1'b1; rep_eot[0] = 1'b1;
        @(negedge clk);
        rep_valid[0] = 1'b0; rep_eot[0] = 1'b0;
    endtask

    // Scenario R6/R7: finite iteration count.
    task automatic t_iter();
        rep_valid = '0; gen_en = 1'b0; rep_sel = 4'b0001;
        iter_limit = '0; iter_limit[IW-1:0] = IW'(2);
        @(negedge clk);
        gen_en = 1'b1;
        eot_beat();
        chk("R6 rewind after pass 1", 64'(rep_rewind[0]), 64'h1);
        chk("R7 not done after pass 1", 64'(rep_done[0]), 64'h0);
        @(negedge clk);
        chk("R6 rewind is one cycle", 64'(rep_rewind[0]), 64'h0);
        eot_beat();
        chk("R6 rewind after pass 2", 64'(rep_rewind[0]), 64'h1);
        chk("R7 done after pass 2", 64'(rep_done[0]), 64'h1);
        rep_valid[0] = 1'b1;
        @(negedge clk);
        chk("R7 replay ready low when done", 64'(rep_ready[0]), 64'h0);
        chk("R7 port silent when done", 64'(out_valid[0]), 64'h0);
        rep_valid[0] = 1'b0;
    endtask

    // Scenario R9: disable clears done and count.
    task automatic t_restart();
        gen_en = 1'b0;
        @(negedge clk);
        chk("R9 done cleared", 64'(rep_done[0]), 64'h0);
        gen_en = 1'b1;
        eot_beat();
        chk("R9 full count again", 64'(rep_done[0]), 64'h0);
        eot_beat();
        chk("R9 done after second pass", 64'(rep_done[0]), 64'h1);
    endtask

    // Scenario R8: zero count repeats forever.
    task automatic t_endless();
        gen_en = 1'b0; iter_limit[IW-1:0] = '0;
        @(negedge clk);
        gen_en = 1'b1;
        for (int p = 0; p < 5; p++) begin
            eot_beat();
            chk("R8 never done", 64'(rep_done[0]), 64'h0);
        end
        chk("R8 rewind still pulses", 64'(rep_rewind[0]), 64'h1);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_select();
        t_boundary();
        t_iter();
        t_restart();
        t_endless();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule